// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is a single timer channel that turns a free-running counter into a pulse-width modulated waveform. An auto-reload counter runs either upward or downward. On every clock it is compared against a compare register, and the result is a reference level. A mode bit can invert that level. A polarity bit and an output enable then shape it before it reaches the pin. Each time the counter lands on the compare value, a sticky match flag is raised.

Software programs the channel through a simple write port with four word addresses. The reload and compare values are written into shadow registers. The counter only adopts them at the end of a period, so a running waveform never shows a half-old, half-new pulse. While the counter is stopped, the shadows are copied straight through, which lets the channel be set up before it starts.

Top module: `pwm_channel`

## Requirements
- R1: Write map (address on `wrAddr`, data on `wrData`): address 0 is control, address 1 is reload, address 2 is compare, and address 3 clears the flag when data bit 0 is 1. The control bits are: bit 0 counter enable, bit 1 direction (0 up, 1 down), bit 2 mode (0 = mode 1, 1 = mode 2), bit 3 polarity (1 = active low), and bit 4 output enable.
- R2: When counting up, the counter steps from 0 to the reload value and then returns to 0, giving a period of reload+1 clocks. In mode 1 the reference is high while the counter is below the compare value. The pin follows the counter state one clock later.
- R3: When counting down, the counter steps from the reload value to 0 and then reloads. In mode 1 the reference is high while the counter is less than or equal to the compare value.
- R4: If the compare value is greater than the reload value, the mode 1 reference is high for the whole period, in either direction.
- R5: With a compare value of 0, the mode 1 reference is low for the whole period when counting up. When counting down it is still high for one clock per period.
- R6: Mode 2 produces the inverse of the mode 1 reference.
- R7: With the output enabled, the pin equals the reference XOR the polarity bit.
- R8: With the output disabled, the pin holds the polarity bit, which is its inactive level, regardless of the counter.
- R9: While the counter is enabled, the match flag is set on the clock after the counter equals the active compare value. It stays set until address 3 is written with bit 0 set. A new match wins over a clear in the same cycle.
- R10: While the counter runs, reload and compare writes take effect only at the period wrap. While the counter is stopped, they take effect on the next clock.
- R11: Reset (active-low `rstN`) clears the counter, every register, the pin and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write word address |
| wrData | input | W | Write data |
| pwmOut | output | 1 | Polarity-adjusted PWM pin |
| matchFlag | output | 1 | Sticky compare-match flag |

## Verification
A write is captured at the clock edge that closes its strobe. The counter and control registers change at that edge. The pin and the flag are registered from the counter state, so each lands one further edge later. The bench drives and samples at falling edges. For duty-cycle checks it waits at least two full periods after the control write and then counts high samples over exactly reload+1 clocks, which makes the result independent of phase. The flag and preload checks synchronise on a falling pin edge and then count samples from that known counter position: 4 low samples before the new compare value applies, then a high run of 7.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP    = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;
  localparam int CTRL_W = 5;

  // bit 0 is cntEn, bit 4 is outEn
  typedef struct packed {
    logic outEn;
    logic pol;
    logic mode;
    logic dir;
    logic cntEn;
  } ctrl_t;

  typedef struct packed {
    logic step;     // advance counter this cycle
    logic wrap;     // end of period reached
    logic latch;    // copy shadows to active
    logic flagClr;  // write-one-to-clear of flag
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      arrAct,
  output ctrl_t             ctrl,
  output logic [W-1:0]      arrShd,
  output logic [W-1:0]      cmpShd,
  output strobe_t           strb
);
  logic atWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl   <= '0;
      arrShd <= '0;
      cmpShd <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL:   ctrl   <= ctrl_t'(wrData[CTRL_W-1:0]);
        A_RELOAD: arrShd <= wrData;
        A_CMP:    cmpShd <= wrData;
        default:  ;
      endcase
    end
  end

  // Down: period ends at zero. Up: period ends at (or past) the reload value.
  assign atWrap = ctrl.dir ? (cnt == '0) : (cnt >= arrAct);

  always_comb begin
    strb.step    = ctrl.cntEn;
    strb.wrap    = ctrl.cntEn & atWrap;
    strb.latch   = ~ctrl.cntEn | atWrap;
    strb.flagClr = wrEn & (wrAddr == A_FLAG) & wrData[0];
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctrl,
  input  strobe_t      strb,
  input  logic [W-1:0] arrShd,
  input  logic [W-1:0] cmpShd,
  output logic [W-1:0] cnt,
  output logic [W-1:0] arrAct,
  output logic [W-1:0] cmpAct,
  output logic         pwmOut,
  output logic         matchFlag
);
  logic refRaw;
  logic refSig;
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.step) begin
      if (strb.wrap) cnt <= ctrl.dir ? arrShd : '0;
      else           cnt <= ctrl.dir ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrAct <= '0;
      cmpAct <= '0;
    end else if (strb.latch) begin
      arrAct <= arrShd;
      cmpAct <= cmpShd;
    end
  end

  // Direction-dependent compare; the held-high and zero cases follow from it.
  assign refRaw = ctrl.dir ? (cnt <= cmpAct) : (cnt < cmpAct);
  assign refSig = refRaw ^ ctrl.mode;
  assign hit    = strb.step & (cnt == cmpAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut    <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      pwmOut <= ctrl.outEn ? (refSig ^ ctrl.pol) : ctrl.pol;
      if (hit)               matchFlag <= 1'b1;
      else if (strb.flagClr) matchFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  output logic              pwmOut,
  output logic              matchFlag
);
  ctrl_t        ctrlQ;
  strobe_t      strb;
  logic [W-1:0] cnt;
  logic [W-1:0] arrAct;
  logic [W-1:0] cmpAct;
  logic [W-1:0] arrShd;
  logic [W-1:0] cmpShd;

  pwm_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cnt    (cnt),
    .arrAct (arrAct),
    .ctrl   (ctrlQ),
    .arrShd (arrShd),
    .cmpShd (cmpShd),
    .strb   (strb)
  );

  pwm_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlQ),
    .strb      (strb),
    .arrShd    (arrShd),
    .cmpShd    (cmpShd),
    .cnt       (cnt),
    .arrAct    (arrAct),
    .cmpAct    (cmpAct),
    .pwmOut    (pwmOut),
    .matchFlag (matchFlag)
  );
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input ctrl_t        ctrl,
  input strobe_t      strb,
  input logic [W-1:0] cnt,
  input logic [W-1:0] arrAct,
  input logic [W-1:0] cmpAct,
  input logic [W-1:0] arrShd,
  input logic         pwmOut,
  input logic         matchFlag
);
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntEn && !ctrl.dir && cnt >= arrAct) |=> (cnt == '0)); // R2

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntEn && ctrl.dir && cnt == '0) |=> (cnt == $past(arrShd))); // R3

  AST_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.outEn && !ctrl.pol && !ctrl.mode && cmpAct > arrAct && cnt <= arrAct) |=> pwmOut); // R4

  AST_ZERO_UP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.outEn && !ctrl.pol && !ctrl.mode && !ctrl.dir && cmpAct == '0) |=> !pwmOut); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.outEn) |-> (pwmOut == $past(ctrl.pol))); // R8

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntEn && cnt == cmpAct) |=> matchFlag); // R9

  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrl.cntEn) && !$past(strb.latch)) |-> $stable(cmpAct)); // R10
endmodule

bind pwm_channel pwm_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrl      (ctrlQ),
  .strb      (strb),
  .cnt       (cnt),
  .arrAct    (arrAct),
  .cmpAct    (cmpAct),
  .arrShd    (arrShd),
  .pwmOut    (pwmOut),
  .matchFlag (matchFlag)
);

// File: tb/pwm_channel_tb.sv
module pwm_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N_VEC = 11;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic [15:0] arr;
    logic [15:0] cmp;
    logic        dir;
    logic        mode;
    logic        pol;
    logic [15:0] high;
  } vec_t;

  // reload, compare, dir, mode, pol, expected high samples per period
  localparam vec_t VEC [N_VEC] = '{
    '{16'd8,  16'd4,  1'b0, 1'b0, 1'b0, 16'd4},  // R2
    '{16'd8,  16'd8,  1'b0, 1'b0, 1'b0, 16'd8},  // R2
    '{16'd8,  16'd9,  1'b0, 1'b0, 1'b0, 16'd9},  // R4 up
    '{16'd8,  16'd0,  1'b0, 1'b0, 1'b0, 16'd0},  // R5 up
    '{16'd8,  16'd4,  1'b1, 1'b0, 1'b0, 16'd5},  // R3
    '{16'd8,  16'd0,  1'b1, 1'b0, 1'b0, 16'd1},  // R5 down
    '{16'd8,  16'd12, 1'b1, 1'b0, 1'b0, 16'd9},  // R4 down
    '{16'd8,  16'd4,  1'b0, 1'b1, 1'b0, 16'd5},  // R6
    '{16'd8,  16'd4,  1'b0, 1'b0, 1'b1, 16'd5},  // R7
    '{16'd5,  16'd2,  1'b1, 1'b1, 1'b0, 16'd3},  // R6 down
    '{16'd3,  16'd1,  1'b0, 1'b0, 1'b1, 16'd3}   // R7
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic         pwmOut;
  logic         matchFlag;
  int checks = 0;
  int fails = 0;

  pwm_channel #(.W(W)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .pwmOut    (pwmOut),
    .matchFlag (matchFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write is captured at the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // control word: {outEn, pol, mode, dir, cntEn}
  function automatic logic [W-1:0] ctl(input logic oe, input logic p, input logic m,
                                       input logic d, input logic en);
    return W'({oe, p, m, d, en});
  endfunction

  task automatic countHigh(input int len, output int ones);
    ones = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwmOut) ones++;
    end
  endtask

  task automatic waitFall();
    int g = 0;
    while (!pwmOut && g < 200) begin @(negedge clk); g++; end
    while (pwmOut && g < 400) begin @(negedge clk); g++; end
    if (g >= 400) check("R2 sync", 0, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ones;
    int lows;
    int highs;
    repeat (3) @(negedge clk);
    check("R11 pin after reset", int'(pwmOut), 0);
    check("R11 flag after reset", int'(matchFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 pin idle", int'(pwmOut), 0);

    // Duty-cycle table
    for (int v = 0; v < N_VEC; v++) begin
      wr(2'd0, ctl(1'b1, VEC[v].pol, VEC[v].mode, VEC[v].dir, 1'b0));
      wr(2'd1, VEC[v].arr);
      wr(2'd2, VEC[v].cmp);
      wr(2'd0, ctl(1'b1, VEC[v].pol, VEC[v].mode, VEC[v].dir, 1'b1));
      repeat (2 * (int'(VEC[v].arr) + 1) + 20) @(negedge clk);
      countHigh(int'(VEC[v].arr) + 1, ones);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v), ones, int'(VEC[v].high));
    end

    // R8: output disabled holds the polarity level
    wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    countHigh(4, ones);
    check("R8 disabled active-low idle", ones, 4);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    countHigh(4, ones);
    check("R8 disabled active-high idle", ones, 0);

    // R9: flag set and clear, up count, reload 8, compare 4
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'd8);
    wr(2'd2, 16'd4);
    wr(2'd3, 16'd1);
    check("R9 flag cleared", int'(matchFlag), 0);
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    waitFall();
    check("R9 flag set on match", int'(matchFlag), 1);
    wr(2'd3, 16'd1);
    check("R9 flag clear by write", int'(matchFlag), 0);
    repeat (3) @(negedge clk);
    check("R9 flag stays clear", int'(matchFlag), 0);
    repeat (10) @(negedge clk);
    check("R9 flag set next period", int'(matchFlag), 1);

    // R10: compare write mid-period waits for the wrap
    waitFall();
    wr(2'd2, 16'd7);
    lows = 0;
    while (!pwmOut && lows < 40) begin lows++; @(negedge clk); end
    check("R10 old compare kept to wrap", lows, 4);
    highs = 0;
    while (pwmOut && highs < 40) begin highs++; @(negedge clk); end
    check("R10 new compare after wrap", highs, 7);

    // R11: reset mid-run
    wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 pin on reset", int'(pwmOut), 0);
    check("R11 flag on reset", int'(matchFlag), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 stays idle after reset", int'(pwmOut), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule